// File: doc/BRIEF.md
# Saturating Sample Integrator

This block sums a stream of signed fixed-point filter samples over periods that a request marks. Each sample is a 16-bit Q1.15 value. The sum is held in an accumulator that keeps the same 15 fractional bits, so a sample is added to it with no scaling. Two multiplexed sample sources feed the block: raw filter output and decimated filter output. A valid strobe goes with each source, and only the selected source is summed.

In absolute mode the sum is unsigned and each sample adds its magnitude. In signed mode the sample is added in two's complement. If the sum overflows, it either clamps or wraps modulo 2^ACC_W. Wrapping is only possible in absolute mode, because signed mode always clamps.

A request ends the current period. It can come from a software strobe or from an asynchronous hardware line. The hardware line is synchronised and then edge-detected according to a selected mode. On a request the block copies the running sum into the result register and moves the internal overflow state into a visible flag. It then starts a new period. A sample that arrives in the same cycle as the request is the first term of the new period.

Top module: `sample_integrator`

## Requirements
- R1: After reset, `final_value` is 0 and `ovf_flag` and `result_valid` are 0. The internal sum is zero and the internal overflow state is clear.
- R2: With `src_sel`=0, samples with `raw_valid`=1 are taken from `raw_sample`. With `src_sel`=1, samples with `dec_valid`=1 are taken from `dec_sample`. The strobe of the unselected source has no effect.
- R3: With `signed_mode`=0, each accepted sample adds its magnitude to an unsigned sum. The sample -32768 (0x8000) adds 32768.
- R4: With `signed_mode`=1, each accepted sample is sign-extended and added in two's complement.
- R5: With `signed_mode`=0 and `sat_en`=1, a sum above 2^ACC_W-1 clamps to all ones (0xFFFFFFFF at the default width).
- R6: With `signed_mode`=0 and `sat_en`=0, a sum above 2^ACC_W-1 wraps modulo 2^ACC_W.
- R7: With `signed_mode`=1, overflow clamps to the largest positive value (0x7FFFFFFF by default) or the most negative value (0x80000000 by default), whatever the value of `sat_en`.
- R8: When a request (`sw_req`=1, or a hardware pulse) is present at a clock edge, that edge loads `final_value` with the sum of the samples accepted before that cycle. The same edge sets `result_valid` for exactly one cycle and restarts the sum from the same-cycle sample, or from 0 if there is none.
- R9: `hw_req` passes through two synchronising flops and then edge detection. The mode encoding in `hw_req_mode` is 00 off, 01 rising, 10 falling, 11 either edge. A qualifying change of `hw_req` before edge k latches the result at edge k+2.
- R10: At a request, `ovf_flag` takes the internal overflow state, which records any overflow since the last clear. The internal state is then cleared.
- R11: When there is no request, `ovf_clr`=1 clears `ovf_flag`. It clears the internal overflow state only when clamping is in effect (`sat_en`=1 or `signed_mode`=1). In wrap mode the overflow is still reported at the next request.
- R12: `integ_rst`=1 zeroes the sum and the internal overflow state. A request in the same cycle is dropped, and `final_value` and `ovf_flag` are left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sel | input | 1 | 0 raw source, 1 decimated source |
| raw_valid | input | 1 | Raw sample strobe |
| raw_sample | input | SAMPLE_W | Raw Q1.15 sample |
| dec_valid | input | 1 | Decimated sample strobe |
| dec_sample | input | SAMPLE_W | Decimated Q1.15 sample |
| signed_mode | input | 1 | 1 signed sum, 0 sum of magnitudes |
| sat_en | input | 1 | 1 clamp on overflow, 0 wrap (absolute mode only) |
| hw_req | input | 1 | Asynchronous hardware request line |
| hw_req_mode | input | 2 | Hardware trigger mode |
| sw_req | input | 1 | Software request strobe |
| ovf_clr | input | 1 | Overflow clear strobe |
| integ_rst | input | 1 | Integrator restart strobe |
| final_value | output | ACC_W | Latched sum of the last period |
| ovf_flag | output | 1 | Overflow seen in the last period |
| result_valid | output | 1 | One-cycle pulse on a new result |

## Verification
Two pairs of events are most likely to meet in one cycle. The first pair is an accepted sample and a request. The bench drives both on one edge, in directed and in random cycles, and expects the sample to appear only in the following period's result. The second pair is an overflow-producing sample and an overflow clear. The bench pushes the sum to each limit while strobing `ovf_clr` at random, in both clamp and wrap modes, and compares each flag and value against a wide-integer model computed from the requirements.

// File: rtl/sint_pkg.sv
// Shared types for the sample integrator.
package sint_pkg;
    // Trigger selection for the hardware request line.
    typedef enum logic [1:0] {
        TRIG_OFF  = 2'b00,
        TRIG_RISE = 2'b01,
        TRIG_FALL = 2'b10,
        TRIG_BOTH = 2'b11
    } trig_mode_e;
endpackage

// File: rtl/sint_req_sync.sv
// Hardware request front end: two-flop synchroniser followed by an edge
// detector. The detector is selected by mode.
// Assumes: req_async may change at any time. The output pulse lasts one cycle.
module sint_req_sync
    import sint_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_async,
    input  logic [1:0] mode,
    output logic       pulse
);
    logic meta_q, sync_q, prev_q;
    logic rise, fall;

    // Synchronise the line and keep last cycle's value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= req_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
    assign fall = ~sync_q & prev_q;

    // Pick the edge(s) that count as a request.
    always_comb begin
        unique case (trig_mode_e'(mode))
            TRIG_RISE: pulse = rise;
            TRIG_FALL: pulse = fall;
            TRIG_BOTH: pulse = rise | fall;
            default:   pulse = 1'b0;
        endcase
    end
endmodule

// File: rtl/sint_term.sv
// Sample conditioning: selects the source and qualifies it with its strobe.
// Then it forms the term to add: sign-extended in signed mode, magnitude in
// absolute mode.
// Assumes: samples are two's complement. ACC_W > SAMPLE_W.
module sint_term #(
    parameter int SAMPLE_W = 16,
    parameter int ACC_W    = 32
) (
    input  logic                src_sel,
    input  logic                raw_valid,
    input  logic [SAMPLE_W-1:0] raw_sample,
    input  logic                dec_valid,
    input  logic [SAMPLE_W-1:0] dec_sample,
    input  logic                signed_mode,
    output logic                term_valid,
    output logic [ACC_W-1:0]    term
);
    localparam int EXT_W = ACC_W - SAMPLE_W;

    logic [SAMPLE_W-1:0] smp;
    logic [SAMPLE_W-1:0] mag;

    // Source multiplexer.
    always_comb begin
        if (src_sel) begin
            smp        = dec_sample;
            term_valid = dec_valid;
        end else begin
            smp        = raw_sample;
            term_valid = raw_valid;
        end
    end

    // Magnitude fits SAMPLE_W unsigned bits, including for the most negative code.
    assign mag = smp[SAMPLE_W-1] ? (~smp + 1'b1) : smp;

    // Widen according to the mode.
    always_comb begin
        if (signed_mode) term = {{EXT_W{smp[SAMPLE_W-1]}}, smp};
        else             term = {{EXT_W{1'b0}}, mag};
    end
endmodule

// File: rtl/sint_accum.sv
// Accumulator with overflow handling and the internal overflow state.
// Priority order: restart, then request, then sample accumulation.
// Assumes: term is already conditioned for the current mode.
// Wrapping only applies in absolute mode.
module sint_accum #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             signed_mode,
    input  logic             sat_en,
    input  logic             term_valid,
    input  logic [ACC_W-1:0] term,
    input  logic             req,
    input  logic             ovf_clr,
    input  logic             integ_rst,
    output logic [ACC_W-1:0] acc_q,
    output logic             ovf_state
);
    localparam logic [ACC_W-1:0] ALL_ONES = '1;
    localparam logic [ACC_W-1:0] POS_MAX  = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] NEG_MIN  = {1'b1, {(ACC_W-1){1'b0}}};

    logic [ACC_W:0]   sum_u, sum_s;
    logic [ACC_W-1:0] add_val;
    logic             add_ovf;
    logic             clamp;

    assign clamp = sat_en | signed_mode;
    assign sum_u = {1'b0, acc_q} + {1'b0, term};
    assign sum_s = {acc_q[ACC_W-1], acc_q} + {term[ACC_W-1], term};

    // Add the term and resolve overflow by mode.
    always_comb begin
        if (signed_mode) begin
            add_ovf = sum_s[ACC_W] ^ sum_s[ACC_W-1];
            if (add_ovf) add_val = sum_s[ACC_W] ? NEG_MIN : POS_MAX;
            else         add_val = sum_s[ACC_W-1:0];
        end else begin
            add_ovf = sum_u[ACC_W];
            add_val = (add_ovf && clamp) ? ALL_ONES : sum_u[ACC_W-1:0];
        end
    end

    // Sum register: restart, period start or accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n || integ_rst)  acc_q <= '0;
        else if (req)             acc_q <= term_valid ? term : '0;
        else if (term_valid)      acc_q <= add_val;
    end

    // Overflow state: set by an overflow, cleared on request, restart or a
    // clear strobe while clamping is in effect.
    always_ff @(posedge clk) begin
        if (!rst_n || integ_rst) ovf_state <= 1'b0;
        else if (req)            ovf_state <= 1'b0;
        else                     ovf_state <= (ovf_state & ~(ovf_clr & clamp))
                                             | (term_valid & add_ovf);
    end
endmodule

// File: rtl/sint_result.sv
// Result stage: latches the sum and the overflow state on a request.
// Gives a one-cycle valid pulse.
// Assumes: req is already suppressed during an integrator restart.
module sint_result #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             ovf_clr,
    input  logic [ACC_W-1:0] acc_q,
    input  logic             ovf_state,
    output logic [ACC_W-1:0] final_value,
    output logic             ovf_flag,
    output logic             result_valid
);
    // Capture the period result and the visible flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            final_value  <= '0;
            ovf_flag     <= 1'b0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= req;
            if (req) begin
                final_value <= acc_q;
                ovf_flag    <= ovf_state;
            end else if (ovf_clr) begin
                ovf_flag    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sample_integrator.sv
// Top level of the sample integrator. It joins the request front end, the
// sample conditioner, the accumulator and the result stage.
// Assumes: all inputs except hw_req are synchronous to clk.
module sample_integrator #(
    parameter int SAMPLE_W = 16,
    parameter int ACC_W    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                src_sel,
    input  logic                raw_valid,
    input  logic [SAMPLE_W-1:0] raw_sample,
    input  logic                dec_valid,
    input  logic [SAMPLE_W-1:0] dec_sample,
    input  logic                signed_mode,
    input  logic                sat_en,
    input  logic                hw_req,
    input  logic [1:0]          hw_req_mode,
    input  logic                sw_req,
    input  logic                ovf_clr,
    input  logic                integ_rst,
    output logic [ACC_W-1:0]    final_value,
    output logic                ovf_flag,
    output logic                result_valid
);
    logic             hw_pulse;
    logic             req;
    logic             term_valid;
    logic [ACC_W-1:0] term;
    logic [ACC_W-1:0] acc_q;
    logic             ovf_state;

    sint_req_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_async (hw_req),
        .mode      (hw_req_mode),
        .pulse     (hw_pulse)
    );

    // A restart in the same cycle drops the request.
    assign req = (sw_req | hw_pulse) & ~integ_rst;

    sint_term #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_term (
        .src_sel     (src_sel),
        .raw_valid   (raw_valid),
        .raw_sample  (raw_sample),
        .dec_valid   (dec_valid),
        .dec_sample  (dec_sample),
        .signed_mode (signed_mode),
        .term_valid  (term_valid),
        .term        (term)
    );

    sint_accum #(.ACC_W(ACC_W)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .signed_mode (signed_mode),
        .sat_en      (sat_en),
        .term_valid  (term_valid),
        .term        (term),
        .req         (req),
        .ovf_clr     (ovf_clr),
        .integ_rst   (integ_rst),
        .acc_q       (acc_q),
        .ovf_state   (ovf_state)
    );

    sint_result #(.ACC_W(ACC_W)) u_res (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (req),
        .ovf_clr      (ovf_clr),
        .acc_q        (acc_q),
        .ovf_state    (ovf_state),
        .final_value  (final_value),
        .ovf_flag     (ovf_flag),
        .result_valid (result_valid)
    );
endmodule

// File: rtl/sint_checker.sv
// Temporal checks on the integrator. Bound to every instance of the top module.
module sint_checker #(
    parameter int ACC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             signed_mode,
    input logic             sat_en,
    input logic             ovf_clr,
    input logic             integ_rst,
    input logic             req,
    input logic             term_valid,
    input logic [ACC_W-1:0] term,
    input logic [ACC_W-1:0] acc_q,
    input logic             ovf_state,
    input logic [ACC_W-1:0] final_value,
    input logic             ovf_flag,
    input logic             result_valid
);
    localparam logic [ACC_W-1:0] POS_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] NEG_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    assert_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        integ_rst |=> (acc_q == '0) && !ovf_state);

    assert_abs_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!signed_mode && sat_en && acc_q == '1 && term_valid && !req && !integ_rst)
        |=> acc_q == '1);

    assert_pos_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (signed_mode && acc_q == POS_MAX && term_valid && !term[ACC_W-1] && !req && !integ_rst)
        |=> acc_q == POS_MAX);

    assert_neg_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (signed_mode && acc_q == NEG_MIN && term_valid && term[ACC_W-1] && !req && !integ_rst)
        |=> acc_q == NEG_MIN);

    assert_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> result_valid && final_value == $past(acc_q));

    assert_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (ovf_flag == $past(ovf_state)) && !ovf_state);

    assert_wrap_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_state && ovf_clr && !signed_mode && !sat_en && !req && !integ_rst)
        |=> ovf_state);
endmodule

bind sample_integrator sint_checker #(.ACC_W(ACC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .signed_mode  (signed_mode),
    .sat_en       (sat_en),
    .ovf_clr      (ovf_clr),
    .integ_rst    (integ_rst),
    .req          (req),
    .term_valid   (term_valid),
    .term         (term),
    .acc_q        (acc_q),
    .ovf_state    (ovf_state),
    .final_value  (final_value),
    .ovf_flag     (ovf_flag),
    .result_valid (result_valid)
);

// File: tb/tb_sample_integrator.sv
// Self-checking bench. A wide-integer model is stepped once per clock and
// compared on every cycle.
module tb_sample_integrator;
    localparam int SW = 16;
    localparam int AW = 24;   // narrower sum so that overflow is reached quickly
    localparam longint ALL1 = (longint'(1) << AW) - 1;
    localparam longint PMAX = (longint'(1) << (AW - 1)) - 1;
    localparam longint NMIN = -(longint'(1) << (AW - 1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic src_sel = 0, raw_valid = 0, dec_valid = 0;
    logic [SW-1:0] raw_sample = '0, dec_sample = '0;
    logic signed_mode = 0, sat_en = 1, hw_req = 0, sw_req = 0, ovf_clr = 0, integ_rst = 0;
    logic [1:0] hw_req_mode = 2'b00;
    logic [AW-1:0] final_value;
    logic ovf_flag, result_valid;

    always #2.5 clk = ~clk;   // 200 MHz

    sample_integrator #(.SAMPLE_W(SW), .ACC_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .raw_valid(raw_valid),
        .raw_sample(raw_sample), .dec_valid(dec_valid), .dec_sample(dec_sample),
        .signed_mode(signed_mode), .sat_en(sat_en), .hw_req(hw_req),
        .hw_req_mode(hw_req_mode), .sw_req(sw_req), .ovf_clr(ovf_clr),
        .integ_rst(integ_rst), .final_value(final_value), .ovf_flag(ovf_flag),
        .result_valid(result_valid)
    );

    int n_vec = 0, n_bad = 0;
    bit done = 0;
    string tag = "R1";
    longint m_acc = 0, m_fv = 0;
    bit m_ovf = 0, m_flag = 0, m_rv = 0, s1 = 0, s2 = 0, sp = 0;

    // Add one sample according to the requirement rules. Returns the new sum in AW bits.
    function automatic longint mdl_add(input longint acc, input logic [SW-1:0] smp,
                                       input bit sgn, input bit sat, output bit ovf);
        longint s, v;
        v = longint'($signed(smp));
        ovf = 0;
        if (sgn) begin
            s = ((acc >> (AW - 1)) & 1) != 0 ? acc - (longint'(1) << AW) : acc;
            s = s + v;
            if (s > PMAX) begin s = PMAX; ovf = 1; end
            else if (s < NMIN) begin s = NMIN; ovf = 1; end
            return s & ALL1;
        end
        s = acc + (v < 0 ? -v : v);
        if (s > ALL1) begin ovf = 1; s = sat ? ALL1 : (s & ALL1); end
        return s;
    endfunction

    task automatic chk(input string what, input longint act, input longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One clock: evaluate the model from the present inputs, clock, then compare at the negedge.
    task automatic step();
        bit hp, req, tv, o;
        logic [SW-1:0] smp;
        longint n_acc;
        bit n_ovf;
        unique case (hw_req_mode)
            2'b01: hp = s2 & ~sp;
            2'b10: hp = ~s2 & sp;
            2'b11: hp = s2 ^ sp;
            default: hp = 0;
        endcase
        req = (sw_req | hp) & ~integ_rst;
        tv  = src_sel ? dec_valid : raw_valid;
        smp = src_sel ? dec_sample : raw_sample;
        n_acc = m_acc; n_ovf = m_ovf;
        if (integ_rst) begin n_acc = 0; n_ovf = 0; end
        else if (req) begin
            n_acc = tv ? mdl_add(0, smp, signed_mode, 1, o) : 0;
            n_ovf = 0;
        end else begin
            if (ovf_clr && (sat_en || signed_mode)) n_ovf = 0;
            if (tv) begin
                n_acc = mdl_add(m_acc, smp, signed_mode, sat_en, o);
                if (o) n_ovf = 1;
            end
        end
        m_rv = req;
        if (req) begin m_fv = m_acc; m_flag = m_ovf; end
        else if (ovf_clr) m_flag = 0;
        m_acc = n_acc; m_ovf = n_ovf;
        @(posedge clk);
        sp = s2; s2 = s1; s1 = hw_req;
        @(negedge clk);
        chk("final_value", longint'(final_value), m_fv);
        chk("ovf_flag", longint'(ovf_flag), longint'(m_flag));
        chk("result_valid", longint'(result_valid), longint'(m_rv));
    endtask

    task automatic idle();
        raw_valid = 0; dec_valid = 0; sw_req = 0; ovf_clr = 0; integ_rst = 0;
    endtask

    // Ask for a result and step past it.
    task automatic request();
        idle(); sw_req = 1; step(); sw_req = 0; step();
    endtask

    task automatic feed(input logic [SW-1:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            raw_valid = 1; raw_sample = v; step();
        end
        raw_valid = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        tag = "R1"; step();
        request();                                   // empty period reads 0

        tag = "R3"; signed_mode = 0; sat_en = 1;
        feed(16'h8000, 1); feed(16'h0003, 1); feed(16'hFFFF, 1);   // 32768+3+1
        request();

        tag = "R4"; signed_mode = 1;
        feed(16'h8000, 1); feed(16'h0005, 2);
        request();

        tag = "R2"; signed_mode = 0; src_sel = 1;
        raw_valid = 1; raw_sample = 16'h7000; dec_valid = 1; dec_sample = 16'h0011; step();
        src_sel = 0; dec_valid = 1; dec_sample = 16'h4000; raw_valid = 1; raw_sample = 16'h0022; step();
        request();

        tag = "R8";                                  // sample in the request cycle
        feed(16'h0100, 2);
        raw_valid = 1; raw_sample = 16'h0040; sw_req = 1; step();
        sw_req = 0; raw_valid = 0; step();
        request();

        tag = "R5"; signed_mode = 0; sat_en = 1;
        feed(16'h7FFF, 520);
        request();
        tag = "R11"; feed(16'h7FFF, 520); ovf_clr = 1; step(); ovf_clr = 0;
        request();                                   // cleared in clamp mode

        tag = "R6"; sat_en = 0;
        feed(16'h8000, 513);
        ovf_clr = 1; step(); ovf_clr = 0;            // clear must not hide a wrap
        tag = "R11"; request();
        tag = "R10"; request();                      // flag drops in a clean period

        tag = "R7"; signed_mode = 1; sat_en = 0;
        feed(16'h7FFF, 260);
        request();
        feed(16'h8000, 256); request();              // lands exactly on the minimum
        feed(16'h8000, 257); request();              // one past

        tag = "R12";
        feed(16'h1234, 4); integ_rst = 1; sw_req = 1; step(); idle(); step();
        request();

        tag = "R9"; signed_mode = 0; sat_en = 1;
        for (int m = 0; m < 4; m++) begin
            hw_req_mode = 2'(m);
            feed(16'h0010, 2);
            hw_req = 1; repeat (4) step();
            feed(16'h0020, 1);
            hw_req = 0; repeat (4) step();
        end
        hw_req_mode = 2'b00;

        tag = "R10";
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(99));
            if (i % 500 == 0) begin
                signed_mode = $urandom_range(1); sat_en = $urandom_range(1);
            end
            src_sel    = $urandom_range(1);
            raw_valid  = (r < 80); dec_valid = (r > 20);
            raw_sample = (r < 40) ? (r[0] ? 16'h8000 : 16'h7FFF) : 16'($urandom);
            dec_sample = 16'($urandom);
            sw_req     = ($urandom_range(199) == 0);
            ovf_clr    = ($urandom_range(49) == 0);
            integ_rst  = ($urandom_range(499) == 0);
            hw_req     = ($urandom_range(99) == 0) ? ~hw_req : hw_req;
            hw_req_mode = (i % 1000 < 500) ? 2'b11 : 2'b00;
            step();
        end
        idle(); request();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule